// File: doc/BRIEF.md
# Tuner Control Register Slave on a Two-Wire Bus

This block is the control port of a broadband tuner. It sits on a two-wire serial bus as a slave and holds a bank of nine 8-bit control registers that set up the tuner's dividers, oscillator tanks, charge pumps and filter offset. A bus master writes them by sending the slave's address, then a register index, then one or more data bytes. The index steps by one after each data byte, so a burst fills consecutive registers.

The 7-bit device address has the fixed prefix `11000`. Its two low bits come from two strap inputs, so up to four tuners can share one bus. A read transfer has no index phase. It returns one status byte built from the two lock indicators, the power-on flag and the two tuning-voltage range flags.

Both bus lines are brought into the system clock domain through synchronizers. START and STOP are found as SDA edges while SCL is high. SDA is driven only as an open-drain pull-down enable. The system clock must run at eight or more times the SCL rate.

Top module: `tuner_i2c_slave`

## Requirements
- R1: The address byte is matched as `{5'b11000, addr_sel_hi, addr_sel_lo, rw}`. This gives 0xC0/0xC1 with both straps low, 0xC2/0xC3 with only `addr_sel_lo` high, 0xC4/0xC5 with only `addr_sel_hi` high, and 0xC6/0xC7 with both high. On a match the slave pulls SDA low for the ninth (acknowledge) clock.
- R2: After an address byte that does not match, the slave acknowledges nothing and changes no register until the next START.
- R3: In a write (rw = 0), the byte after the address is the register index, and it is acknowledged. Every data byte after the index is also acknowledged.
- R4: A data byte is stored into the register selected by the current index, and the index then advances by one. Register k appears on `ctrl_regs_o[8k+7:8k]`.
- R5: A data byte whose index is above 8 is acknowledged but discarded. The index does not wrap back to 0.
- R6: In a read (rw = 1), the slave acknowledges the address and then sends one status byte, MSB first. From bit 7 down, the byte holds `lo1_locked`, `lo2_locked`, `por_done`, `lo1_tune_oor` and `lo2_tune_oor`. Bits 2 to 0 read as 0.
- R7: After the eighth bit of the status byte, the slave releases SDA and stays released until the next START.
- R8: A START seen in any state, including mid-byte, abandons the current transfer. The slave then expects a new address byte, and the partial byte writes nothing.
- R9: A STOP seen mid-byte abandons the transfer and writes nothing. The slave then waits idle for a START.
- R10: After reset all nine registers read 0 and SDA is released.
- R11: The slave changes its SDA drive only while SCL is low.
- R12: Data bits are taken MSB first. The first bit after the acknowledge becomes bit 7 of the stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| addr_sel_hi | input | 1 | Strap for device address bit 2 |
| addr_sel_lo | input | 1 | Strap for device address bit 1 |
| lo1_locked | input | 1 | First synthesizer lock indicator (status bit 7) |
| lo2_locked | input | 1 | Second synthesizer lock indicator (status bit 6) |
| por_done | input | 1 | Power-on reset completed flag (status bit 5) |
| lo1_tune_oor | input | 1 | First oscillator tuning voltage out of range (status bit 4) |
| lo2_tune_oor | input | 1 | Second oscillator tuning voltage out of range (status bit 3) |
| ctrl_regs_o | output | 72 | Nine control registers, register k at bits 8k+7:8k |

## Verification
The hardest case to reach is a bus condition in the middle of a byte. A START or STOP arriving after only some data bits have been shifted in must leave the register bank untouched. The bench reaches this with a bit-level master that sends only four or five bits of a data byte and then issues a START or STOP from the SCL-low phase. A scoreboard monitor flags any register change it was not told to expect. The bench also crosses a burst past index 8 to show that the extra bytes are acknowledged and that nothing wraps into register 0.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_CNT_W = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INDEX,
    ST_DATA,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_st_e;
endpackage

// File: rtl/tuner_i2c_linesync.sv
module tuner_i2c_linesync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff;
  logic [SYNC_STAGES-1:0] sda_ff;
  logic                   scl_prev;
  logic                   sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_ff[SYNC_STAGES-1];
      sda_prev <= sda_ff[SYNC_STAGES-1];
    end
  end

  always_comb begin
    scl_s     = scl_ff[SYNC_STAGES-1];
    sda_s     = sda_ff[SYNC_STAGES-1];
    scl_rise  = scl_s & ~scl_prev;
    scl_fall  = ~scl_s & scl_prev;
    start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
  end

  // R8
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, stop_det}));

endmodule

// File: rtl/tuner_i2c_fsm.sv
module tuner_i2c_fsm
  import tuner_i2c_pkg::*;
#(
  parameter logic [4:0]  DEV_PREFIX = 5'b11000,
  parameter int unsigned IDX_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        strap,
  input  logic [BYTE_W-1:0] status,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  bus_st_e                st_q, st_d;
  bus_st_e                ack_nxt_q, ack_nxt_d;
  logic [BYTE_W-1:0]      shreg_q, shreg_d;
  logic [BIT_CNT_W-1:0]   bitcnt_q, bitcnt_d;
  logic                   done_q, done_d;
  logic                   oe_q, oe_d;
  logic [IDX_W-1:0]       idx_q, idx_d;
  logic                   addr_hit;
  logic                   byte_end;

  assign addr_hit = (shreg_q[BYTE_W-1:1] == {DEV_PREFIX, strap});
  assign byte_end = scl_fall & done_q;

  always_comb begin
    st_d      = st_q;
    ack_nxt_d = ack_nxt_q;
    shreg_d   = shreg_q;
    bitcnt_d  = bitcnt_q;
    done_d    = done_q;
    oe_d      = oe_q;
    idx_d     = idx_q;
    wr_en     = 1'b0;
    if (start_det) begin
      st_d     = ST_ADDR;
      bitcnt_d = '0;
      done_d   = 1'b0;
      oe_d     = 1'b0;
    end else if (stop_det) begin
      st_d   = ST_IDLE;
      done_d = 1'b0;
      oe_d   = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_INDEX, ST_DATA: begin
          if (scl_rise && !done_q) begin
            shreg_d  = {shreg_q[BYTE_W-2:0], sda_s};
            bitcnt_d = bitcnt_q + 1'b1;
            if (bitcnt_q == BIT_CNT_W'(BYTE_W - 1)) done_d = 1'b1;
          end else if (byte_end) begin
            done_d = 1'b0;
            st_d   = ST_ACK;
            oe_d   = 1'b1;
            if (st_q == ST_ADDR) begin
              if (addr_hit) begin
                ack_nxt_d = shreg_q[0] ? ST_TX : ST_INDEX;
              end else begin
                st_d = ST_IDLE;
                oe_d = 1'b0;
              end
            end else if (st_q == ST_INDEX) begin
              idx_d     = shreg_q;
              ack_nxt_d = ST_DATA;
            end else begin
              wr_en     = 1'b1;
              ack_nxt_d = ST_DATA;
              if (idx_q != '1) idx_d = idx_q + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            st_d     = ack_nxt_q;
            bitcnt_d = '0;
            if (ack_nxt_q == ST_TX) begin
              shreg_d = status;
              oe_d    = ~status[BYTE_W-1];
            end else begin
              oe_d = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == BIT_CNT_W'(BYTE_W - 1)) begin
              st_d = ST_MACK;
              oe_d = 1'b0;
            end else begin
              shreg_d  = {shreg_q[BYTE_W-2:0], 1'b0};
              oe_d     = ~shreg_q[BYTE_W-2];
              bitcnt_d = bitcnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) st_d = ST_IDLE;
        end
        default: begin
          st_d = ST_IDLE;
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ack_nxt_q <= ST_IDLE;
      shreg_q   <= '0;
      bitcnt_q  <= '0;
      done_q    <= 1'b0;
      oe_q      <= 1'b0;
      idx_q     <= '0;
    end else begin
      st_q      <= st_d;
      ack_nxt_q <= ack_nxt_d;
      shreg_q   <= shreg_d;
      bitcnt_q  <= bitcnt_d;
      done_q    <= done_d;
      oe_q      <= oe_d;
      idx_q     <= idx_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_idx  = idx_q;
  assign wr_data = shreg_q;

  // R8
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_q == ST_ADDR) && (bitcnt_q == '0) && !done_q);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st_q == ST_IDLE) && !oe_q);

  // R2
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR && byte_end && !addr_hit && !start_det && !stop_det)
      |=> (st_q == ST_IDLE) && !oe_q);

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (idx_q == $past(idx_q) + 1'b1) || ($past(idx_q) == '1 && idx_q == '1));

endmodule

// File: rtl/tuner_i2c_regbank.sv
module tuner_i2c_regbank #(
  parameter int unsigned NREG  = 9,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned DW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          hit;
    logic [DW-1:0] q;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= wr_data;
      end
    end

    assign regs_o[g*DW +: DW] = q;
  end

  // R5
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= IDX_W'(NREG))) |=> $stable(regs_o));

endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave
  import tuner_i2c_pkg::*;
#(
  parameter int unsigned NREG        = 9,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [4:0]  DEV_PREFIX  = 5'b11000,
  localparam int unsigned IDX_W      = BYTE_W,
  localparam int unsigned REGS_W     = NREG * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              addr_sel_hi,
  input  logic              addr_sel_lo,
  input  logic              lo1_locked,
  input  logic              lo2_locked,
  input  logic              por_done,
  input  logic              lo1_tune_oor,
  input  logic              lo2_tune_oor,
  output logic [REGS_W-1:0] ctrl_regs_o
);
  logic [1:0]        rst_sync;
  logic              rst_n_s;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  assign status = {lo1_locked, lo2_locked, por_done, lo1_tune_oor, lo2_tune_oor, 3'b000};

  tuner_i2c_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tuner_i2c_fsm #(.DEV_PREFIX(DEV_PREFIX), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .strap({addr_sel_hi, addr_sel_lo}), .status(status),
    .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  tuner_i2c_regbank #(.NREG(NREG), .IDX_W(IDX_W), .DW(BYTE_W)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(ctrl_regs_o)
  );

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

endmodule

// File: tb/tuner_i2c_slave_tb.sv
module tuner_i2c_slave_tb_top;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic        sel_hi = 1'b0, sel_lo = 1'b0;
  logic        lk1 = 1'b0, lk2 = 1'b0, por = 1'b0, oor1 = 1'b0, oor2 = 1'b0;
  logic [71:0] regs;
  wire         bus_sda = sda_m & ~sda_oe;

  int n_run = 0;
  int n_fail = 0;

  typedef struct { int idx; int val; } exp_t;
  exp_t exp_q[$];
  logic        mon_en = 1'b0;
  logic [71:0] regs_prev;
  logic        oe_prev;

  always #5 clk = ~clk;

  tuner_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus_sda), .sda_oe_o(sda_oe),
    .addr_sel_hi(sel_hi), .addr_sel_lo(sel_lo),
    .lo1_locked(lk1), .lo2_locked(lk2), .por_done(por),
    .lo1_tune_oor(oor1), .lo2_tune_oor(oor2), .ctrl_regs_o(regs)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    @(negedge clk); ack = ~bus_sda;
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
      @(negedge clk); b[i] = bus_sda;
      wq(Q); scl = 1'b0; wq(Q);
    end
    send_bit(~m_ack);
  endtask

  // driver: write a byte, expect ack, push the expected register update
  task automatic wr_data(input int idx, input logic [7:0] v, input string tag);
    logic a;
    if (idx < 9) begin
      exp_t e; e.idx = idx; e.val = int'(v); exp_q.push_back(e);
    end
    send_byte(v, a);
    chk(tag, int'(a), 1);
  endtask

  // scoreboard monitor: every register change must match the queue head (R4, R12)
  always @(negedge clk) begin
    if (mon_en) begin
      for (int i = 0; i < 9; i++) begin
        if (regs[i*8 +: 8] != regs_prev[i*8 +: 8]) begin
          if (exp_q.size() == 0) begin
            chk("R4 unexpected register write", i, -1);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R4 write index", i, e.idx);
            chk("R12 write value", int'(regs[i*8 +: 8]), e.val);
          end
        end
      end
      // R11: drive changes only while SCL low
      if (sda_oe != oe_prev) chk("R11 sda drive change with SCL high", int'(scl), 0);
    end
    regs_prev = regs;
    oe_prev   = sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] rb;
    wq(5); rst_n = 1'b1; wq(5);
    @(negedge clk);
    chk("R10 registers after reset", int'(regs == 72'd0), 1);
    chk("R10 SDA released after reset", int'(sda_oe), 0);
    mon_en = 1'b1;

    // straps 00: burst write from index 0
    sel_hi = 0; sel_lo = 0; wq(4);
    bus_start();
    send_byte(8'hC0, a); chk("R1 ack addr C0", int'(a), 1);
    send_byte(8'h00, a); chk("R3 ack index", int'(a), 1);
    wr_data(0, 8'hA1, "R3 ack data r0");
    wr_data(1, 8'hB2, "R4 ack data r1");
    wr_data(2, 8'hC3, "R4 ack data r2");
    bus_stop();

    // straps 01 -> C2
    sel_hi = 0; sel_lo = 1; wq(4);
    bus_start();
    send_byte(8'hC2, a); chk("R1 ack addr C2", int'(a), 1);
    send_byte(8'h06, a); chk("R3 ack index 6", int'(a), 1);
    wr_data(6, 8'h6E, "R4 ack data r6");
    bus_stop();

    // straps 10 -> C4, and C0 must be ignored
    sel_hi = 1; sel_lo = 0; wq(4);
    bus_start();
    send_byte(8'hC4, a); chk("R1 ack addr C4", int'(a), 1);
    send_byte(8'h05, a); chk("R3 ack index 5", int'(a), 1);
    wr_data(5, 8'h5A, "R4 ack data r5");
    bus_stop();
    bus_start();
    send_byte(8'hC0, a); chk("R2 no ack foreign addr", int'(a), 0);
    send_byte(8'h03, a); chk("R2 no ack after foreign addr", int'(a), 0);
    send_byte(8'h77, a); chk("R2 no ack data after foreign addr", int'(a), 0);
    bus_stop();

    // straps 11 -> C6: burst past index 8
    sel_hi = 1; sel_lo = 1; wq(4);
    bus_start();
    send_byte(8'hC6, a); chk("R1 ack addr C6", int'(a), 1);
    send_byte(8'h07, a); chk("R3 ack index 7", int'(a), 1);
    wr_data(7, 8'h11, "R4 ack data r7");
    wr_data(8, 8'h22, "R4 ack data r8");
    wr_data(9, 8'h33, "R5 ack discarded byte idx 9");
    wr_data(10, 8'h44, "R5 ack discarded byte idx 10");
    bus_stop();
    bus_start();
    send_byte(8'hC6, a); chk("R1 ack addr C6 again", int'(a), 1);
    send_byte(8'h0C, a); chk("R5 ack index 0C", int'(a), 1);
    wr_data(12, 8'h99, "R5 ack discarded byte idx 0C");
    bus_stop();
    wq(4);
    chk("R5 no wrap into r0", int'(regs[7:0]), 'hA1);
    chk("R5 r8 holds last valid", int'(regs[71:64]), 'h22);

    // reads
    lk1 = 1; lk2 = 0; por = 1; oor1 = 0; oor2 = 1; wq(4);
    bus_start();
    send_byte(8'hC7, a); chk("R6 ack read addr", int'(a), 1);
    recv_byte(1'b0, rb); chk("R6 status A8", int'(rb), 'hA8);
    chk("R7 released after status", int'(sda_oe), 0);
    bus_stop();
    lk1 = 0; lk2 = 1; por = 0; oor1 = 1; oor2 = 0; wq(4);
    bus_start();
    send_byte(8'hC7, a); chk("R6 ack read addr 2", int'(a), 1);
    recv_byte(1'b0, rb); chk("R6 status 50", int'(rb), 'h50);
    chk("R7 released after second status", int'(sda_oe), 0);
    bus_stop();

    // START mid-byte
    bus_start();
    send_byte(8'hC6, a); chk("R8 ack addr", int'(a), 1);
    send_byte(8'h02, a); chk("R8 ack index 2", int'(a), 1);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start();
    send_byte(8'hC6, a); chk("R8 ack addr after restart", int'(a), 1);
    send_byte(8'h03, a); chk("R8 ack index 3", int'(a), 1);
    wr_data(3, 8'h3C, "R8 ack data r3");
    bus_stop();
    wq(4);
    chk("R8 r2 untouched by partial byte", int'(regs[23:16]), 'hC3);

    // STOP mid-byte
    bus_start();
    send_byte(8'hC6, a); chk("R9 ack addr", int'(a), 1);
    send_byte(8'h04, a); chk("R9 ack index 4", int'(a), 1);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_stop();
    wq(4);
    chk("R9 r4 untouched by partial byte", int'(regs[39:32]), 0);
    chk("R9 SDA released after stop", int'(sda_oe), 0);

    wq(20);
    chk("R4 all expected writes seen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule